// File: doc/BRIEF.md
# Crossbar Interconnect with Per-Crosspoint Compacting Delay Files

This block connects the result outputs of a small group of processing elements (PEs) to their operand inputs. Each PE owns one row, driven by its result, and two columns: one feeds its left operand and one feeds its right operand. At every row/column intersection sits a private delay file. A value written into a crosspoint can be read back any number of cycles later without touching any other path. A producer can copy one result into any subset of its row's crosspoints in a single cycle.

Each delay file holds values packed into its lowest locations. Writes land in the first empty slot. A read names a location directly, and can also retire the value it reads. Retiring a value shifts every newer value down one place. Each column picks one crosspoint per cycle through a row select, a location and a retire flag, and presents the value on a registered operand output. The PEs, the sequencer and the program memory that drive the control fields are outside this block.

Top module: `xbar_delay_top`

## Requirements
- R1: During reset and on the first cycle after it, every `op_valid` bit is 0, every `op_data` lane is 0 and `err` is 0. After reset every delay file is empty.
- R2: Setting bit `r*2N + c` of `wr_mask` (N PEs; column `2p` is the left operand of PE p and `2p+1` is its right operand) writes row r's `wr_data` lane into crosspoint (r, c). The value goes into the lowest empty location of that file. Several bits may be set in one cycle.
- R3: Column c with `col_rd_en[c]` high reads location `col_addr` of the crosspoint in the row named by `col_sel`. The value appears on `op_data` lane c with `op_valid[c]` high one clock later. When no read is made, the lane shows valid 0 and data 0.
- R4: Reading the location equal to a file's current fill count, in the same cycle that this file is written, returns the incoming value with no added delay.
- R5: A read with `col_del` set retires the value read. Every value above it moves down one location. Only the selected crosspoint changes.
- R6: When a retire and a write hit one file in the same cycle, the new value lands in the location just above the compacted contents.
- R7: A retire of a forwarded value (R4 with `col_del`) leaves that value out of the file.
- R8: A stored value stays readable, unchanged, for any number of idle cycles.
- R9: A write to a full file with no retire in that cycle is dropped and raises `err`. The stored contents are kept.
- R10: A read or retire of a location at or above the fill count (and not forwarded) returns valid 0, raises `err` and leaves the file unchanged.
- R11: `err` stays high from the cycle after the first error until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mask | input | NUM_PE*2*NUM_PE (8) | Per-crosspoint write enables, bit r*2N+c |
| wr_data | input | NUM_PE*DATA_W (32) | Result of each PE, lane r at [r*DATA_W +: DATA_W] |
| col_rd_en | input | 2*NUM_PE (4) | Read request per column |
| col_sel | input | 2*NUM_PE*RSW (4) | Row select per column |
| col_addr | input | 2*NUM_PE*AW (12) | Location to read per column |
| col_del | input | 2*NUM_PE (4) | Retire the read value, per column |
| op_data | output | 2*NUM_PE*DATA_W (64) | Registered operand per column |
| op_valid | output | 2*NUM_PE (4) | Registered read success per column |
| err | output | 1 | Sticky overflow or bad-location flag |

## Verification
A corrupted fill count or a broken compaction shows up on the ports at the next read of that crosspoint. The read either returns the neighbour of the expected value one clock later, or it reports valid 0 together with a rising `err`. The stimulus retires values from the bottom and from the middle, with and without a write in the same cycle, and reads back every location that moved. Any off-by-one in the shift or in the write slot therefore surfaces within one or two cycles. Multicast and row-select errors show up as a wrong value on a column that should hold another row's data, or as a spurious error on a column that should be empty.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  // Column numbering: left operand of PE p, then its right operand.
  function automatic int xb_col(input int pe, input int is_right);
    return 2 * pe + is_right;
  endfunction
endpackage

// File: rtl/xbar_dly_elem.sv
module xbar_dly_elem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_del,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit,
  output logic              ovf
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0]     fill;
  logic              full, fwd, stored, del_st, wr_take;
  logic [CW-1:0]     wpos;

  always_comb begin
    full    = (fill == CW'(DEPTH));
    stored  = rd_en && (CW'(rd_addr) < fill);
    fwd     = rd_en && wr_en && (CW'(rd_addr) == fill);
    rd_hit  = stored || fwd;
    del_st  = stored && rd_del;
    // forwarded-and-retired value is never stored
    wr_take = wr_en && !(fwd && rd_del) && (!full || del_st);
    ovf     = wr_en && full && !del_st;
    wpos    = del_st ? fill - CW'(1) : fill;
    rd_data = fwd ? wr_data : mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (del_st && i >= int'(rd_addr)) mem[i] <= mem[i+1];
    end
    if (wr_take) mem[wpos[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) fill <= '0;
    else     fill <= fill + CW'(wr_take) - CW'(del_st);
  end

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));
  p_ovf_keeps_full_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_del) |=> (fill == CW'(DEPTH)));
  p_fill_step_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fill == $past(fill) || fill == $past(fill) + CW'(1) ||
              fill + CW'(1) == $past(fill)));
  p_bad_read_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_hit && !wr_en) |=> $stable(fill));
endmodule

// File: rtl/xbar_col_port.sv
module xbar_col_port #(
  parameter int NROW   = 2,
  parameter int DATA_W = 16,
  parameter int RSW    = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [RSW-1:0]         sel,
  input  logic [NROW-1:0]        hit,
  input  logic [NROW*DATA_W-1:0] data,
  output logic [DATA_W-1:0]      op_data,
  output logic                   op_valid,
  output logic                   bad
);
  logic              hit_s;
  logic [DATA_W-1:0] dsel;

  always_comb begin
    hit_s = 1'b0;
    dsel  = '0;
    for (int r = 0; r < NROW; r++) begin
      if (sel == RSW'(r)) begin
        hit_s = hit[r];
        dsel  = data[r*DATA_W +: DATA_W];
      end
    end
    bad = rd_en && !hit_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid <= 1'b0;
      op_data  <= '0;
    end else begin
      op_valid <= rd_en && hit_s;
      op_data  <= (rd_en && hit_s) ? dsel : '0;
    end
  end

  p_valid_needs_read_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !op_valid);
  p_idle_data_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> (op_data == '0));
endmodule

// File: rtl/xbar_delay_top.sv
module xbar_delay_top #(
  parameter int NUM_PE = 2,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int NCOL  = 2 * NUM_PE,
  localparam int AW    = $clog2(DEPTH),
  localparam int RSW   = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_PE*NCOL-1:0]   wr_mask,
  input  logic [NUM_PE*DATA_W-1:0] wr_data,
  input  logic [NCOL-1:0]          col_rd_en,
  input  logic [NCOL*RSW-1:0]      col_sel,
  input  logic [NCOL*AW-1:0]       col_addr,
  input  logic [NCOL-1:0]          col_del,
  output logic [NCOL*DATA_W-1:0]   op_data,
  output logic [NCOL-1:0]          op_valid,
  output logic                     err
);
  logic [NCOL-1:0][NUM_PE-1:0]        hit_m;
  logic [NCOL-1:0][NUM_PE*DATA_W-1:0] dat_m;
  logic [NUM_PE*NCOL-1:0]             ovf_v;
  logic [NCOL-1:0]                    bad_v;

  for (genvar r = 0; r < NUM_PE; r++) begin : g_row
    for (genvar c = 0; c < NCOL; c++) begin : g_xp
      logic pick;
      assign pick = col_rd_en[c] && (col_sel[c*RSW +: RSW] == RSW'(r));
      xbar_dly_elem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_elem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_mask[r*NCOL + c]),
        .wr_data (wr_data[r*DATA_W +: DATA_W]),
        .rd_en   (pick),
        .rd_del  (col_del[c]),
        .rd_addr (col_addr[c*AW +: AW]),
        .rd_data (dat_m[c][r*DATA_W +: DATA_W]),
        .rd_hit  (hit_m[c][r]),
        .ovf     (ovf_v[r*NCOL + c])
      );
    end
  end

  for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
    for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int C = xbar_pkg::xb_col(p, s);
      xbar_col_port #(.NROW(NUM_PE), .DATA_W(DATA_W), .RSW(RSW)) u_col (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (col_rd_en[C]),
        .sel      (col_sel[C*RSW +: RSW]),
        .hit      (hit_m[C]),
        .data     (dat_m[C]),
        .op_data  (op_data[C*DATA_W +: DATA_W]),
        .op_valid (op_valid[C]),
        .bad      (bad_v[C])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= err | (|ovf_v) | (|bad_v);
  end

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  p_err_on_bad_r10: assert property (@(posedge clk) disable iff (rst)
    (|bad_v) |=> err);
endmodule

// File: tb/sim_xbar_delay_top.sv
module sim_xbar_delay_top;
  localparam int NUM_PE = 2, DATA_W = 16, DEPTH = 8;
  localparam int NCOL = 4, AW = 3, RSW = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0]  wr_mask = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  col_rd_en = '0, col_sel = '0, col_del = '0;
  logic [11:0] col_addr = '0;
  logic [63:0] op_data;
  logic [3:0]  op_valid;
  logic        err;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xbar_delay_top #(.NUM_PE(NUM_PE), .DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .wr_mask(wr_mask), .wr_data(wr_data),
    .col_rd_en(col_rd_en), .col_sel(col_sel), .col_addr(col_addr),
    .col_del(col_del), .op_data(op_data), .op_valid(op_valid), .err(err));

  // {mask[8], wd0[16], wd1[16], en, sel, addr[3], del, expv, expd[16]}
  localparam logic [62:0] TBL [13] = '{
    {8'h01, 16'hA001, 16'h0,    1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 16'hA001}, // R4 fwd
    {8'h01, 16'hA002, 16'h0,    1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 16'h0},    // R3 idle
    {8'h10, 16'h0,    16'hB001, 1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 16'hA002}, // R2/R3
    {8'h00, 16'h0,    16'h0,    1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 16'hA001}, // R5 del
    {8'h00, 16'h0,    16'h0,    1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 16'hA002}, // R5 shift
    {8'h00, 16'h0,    16'h0,    1'b1, 1'b1, 3'd0, 1'b0, 1'b1, 16'hB001}, // R5 other xp
    {8'h07, 16'hA003, 16'h0,    1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 16'hA003}, // R2 mcast
    {8'h01, 16'hA004, 16'h0,    1'b1, 1'b0, 3'd1, 1'b1, 1'b1, 16'hA003}, // R6
    {8'h00, 16'h0,    16'h0,    1'b1, 1'b0, 3'd1, 1'b0, 1'b1, 16'hA004}, // R6 slot
    {8'h01, 16'hA005, 16'h0,    1'b1, 1'b0, 3'd2, 1'b1, 1'b1, 16'hA005}, // R7
    {8'h00, 16'h0,    16'h0,    1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 16'hA002}, // R5
    {8'h00, 16'h0,    16'h0,    1'b1, 1'b0, 3'd0, 1'b1, 1'b1, 16'hA004}, // R7 empties
    {8'h01, 16'hA006, 16'h0,    1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 16'hA006}  // R7 no A005
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear();
    wr_mask = '0; wr_data = '0; col_rd_en = '0; col_sel = '0;
    col_addr = '0; col_del = '0;
  endtask

  task automatic rd(input int c, input int s, input int a, input bit d);
    col_rd_en[c] = 1'b1;
    col_sel[c*RSW +: RSW] = RSW'(s);
    col_addr[c*AW +: AW] = AW'(a);
    col_del[c] = d;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    clear(); rst = 1'b1; step(); step(); rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(); step(); step();
    chk("R1 valid in reset", 32'(op_valid), 32'h0);
    chk("R1 err in reset", 32'(err), 32'h0);
    rst = 1'b0;
    step();
    chk("R1 data after reset", op_data[31:0], 32'h0);

    for (int i = 0; i < 13; i++) begin
      logic [62:0] e;
      e = TBL[i];
      clear();
      wr_mask = e[62:55];
      wr_data = {e[38:23], e[54:39]};
      if (e[22]) rd(0, int'(e[21]), int'(e[20:18]), e[17]);
      step();
      chk($sformatf("R3 table valid step %0d", i), 32'(op_valid[0]), 32'(e[16]));
      chk($sformatf("R3 table data step %0d", i), 32'(op_data[15:0]), 32'(e[15:0]));
    end

    // R2 multicast reached columns 1 and 2
    clear(); rd(1, 0, 0, 0); rd(2, 0, 0, 0); step();
    chk("R2 mcast col1", 32'(op_data[31:16]), 32'hA003);
    chk("R2 mcast col2", 32'(op_data[47:32]), 32'hA003);
    chk("R11 no err yet", 32'(err), 32'h0);

    // R10 read of empty crosspoint
    clear(); rd(3, 0, 0, 0); step();
    chk("R10 bad read valid", 32'(op_valid[3]), 32'h0);
    chk("R10 bad read err", 32'(err), 32'h1);
    clear(); step(); step();
    chk("R11 err sticky", 32'(err), 32'h1);

    do_reset(); step();
    chk("R1 err cleared", 32'(err), 32'h0);
    clear(); rd(0, 0, 0, 0); step();
    chk("R1 empty after reset", 32'(op_valid[0]), 32'h0);

    // R8 long hold, row 1 into column 3
    do_reset();
    wr_mask = 8'h80; wr_data = {16'hC0DE, 16'h0}; step();
    clear(); repeat (50) step();
    rd(3, 1, 0, 0); step();
    chk("R8 hold value", 32'(op_data[63:48]), 32'hC0DE);
    chk("R8 hold valid", 32'(op_valid[3]), 32'h1);

    // R9 overflow
    do_reset();
    for (int i = 0; i < 8; i++) begin
      clear(); wr_mask = 8'h01; wr_data = 32'(16'h0100 + i); step();
    end
    chk("R9 full no err", 32'(err), 32'h0);
    clear(); wr_mask = 8'h01; wr_data = 32'h0000_0999; step();
    chk("R9 overflow err", 32'(err), 32'h1);
    clear(); rd(0, 0, 7, 0); step();
    chk("R9 top kept", 32'(op_data[15:0]), 32'h0107);

    // R10 bad retire leaves contents
    do_reset();
    wr_mask = 8'h02; wr_data = 32'h0000_00D1; step();
    clear(); rd(1, 0, 1, 1); step();
    chk("R10 bad del valid", 32'(op_valid[1]), 32'h0);
    chk("R10 bad del err", 32'(err), 32'h1);
    clear(); rd(1, 0, 0, 0); step();
    chk("R10 contents kept", 32'(op_data[31:16]), 32'h00D1);

    clear(); step();
    finish_run();
  end
endmodule